// File: doc/BRIEF.md
# Capture Source Select and Edge Prescaler

This block is the front end of one capture channel of a timer. It chooses which signal the channel watches: one of two filtered timer inputs or the internal trigger. The select code can also turn the channel into an output, and then the block produces no capture events. Rising edges on the chosen source are counted. Only every k-th edge is passed on, as a capture pulse one clock cycle wide. Latching the counter value and raising flags happen further down the chain, outside this block.

Configuration arrives through one write strobe that carries a 2-bit select code and a 2-bit prescaler code. The prescaler code is taken on every write. The select code is taken only while the channel is disabled, so the source cannot change under a running capture. The edge counter restarts whenever the channel is disabled and whenever a write changes the prescaler code. After a restart, the first capture comes on the k-th edge.

Top module: `capsel_front`

## Requirements
- R1: While reset is asserted and after it is released, `cap_pulse` is 0, the select code is 00 (output mode, no capture) and the prescaler code is 00 (ratio 1).
- R2: With select code 00 the block emits no capture pulse, whatever the three inputs do.
- R3: With select code 01 the channel watches `tin2`. The other two inputs have no effect.
- R4: With select code 10 the channel watches `tin1`. The other two inputs have no effect.
- R5: With select code 11 the channel watches `trig_in`. The other two inputs have no effect.
- R6: A write made while `chan_en` is 1 leaves the select code unchanged. The prescaler code of that same write is still taken.
- R7: Prescaler codes 00, 01, 10 and 11 give one capture per 1, 2, 4 and 6 rising edges. After a restart, the first capture comes on the k-th edge.
- R8: Driving `chan_en` to 0 for at least one cycle clears the edge count.
- R9: A write that changes the prescaler code clears the edge count, and an edge sampled in that cycle is not counted. A write of the same code leaves the count as it was.
- R10: Only rising edges count. `cap_pulse` is high for exactly one cycle: the cycle after the clock edge at which the rising edge on the source was sampled.
- R11: While `chan_en` is 0 no capture pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tin1 | input | 1 | Filtered timer input 1 |
| tin2 | input | 1 | Filtered timer input 2 |
| trig_in | input | 1 | Internal trigger |
| chan_en | input | 1 | Channel enable |
| cfg_wr | input | 1 | Configuration write strobe |
| sel_wdata | input | 2 | Select code: 00 output, 01 tin2, 10 tin1, 11 trig_in |
| psc_wdata | input | 2 | Prescaler code: 00/01/10/11 give ratio 1/2/4/6 |
| cap_pulse | output | 1 | Single-cycle capture event |

## Verification
The hardest states to reach are the internal edge-count values, which never appear at a port. Of these, the one that matters most is a partly filled count at the moment the channel is disabled or the prescaler code is rewritten. The stimulus sends a chosen number of edges short of the ratio, then disables the channel or writes the prescaler code, then counts how many further edges pass before a pulse appears. Rewriting the same prescaler code is run beside a real code change, so that the two cases can be told apart. A select write made while the channel is enabled is exposed the same way: edges are then driven on both the old source and the new one.

// File: rtl/capsel_pkg.sv
package capsel_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_TI2  = 2'b01,
      SRC_TI1  = 2'b10,
      SRC_TRIG = 2'b11
   } src_sel_e;

   localparam int N_SRC     = 3;
   localparam int MAX_RATIO = 6;

   // Prescaler code to edges-per-capture.
   function automatic int psc_ratio(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 4;
         default: return 6;
      endcase
   endfunction

   // Select code to source index (0: tin2, 1: tin1, 2: trig_in).
   function automatic int src_index(input src_sel_e sel);
      case (sel)
         SRC_TI2: return 0;
         SRC_TI1: return 1;
         default: return 2;
      endcase
   endfunction

endpackage

// File: rtl/capsel_cfg.sv
module capsel_cfg
   import capsel_pkg::*;
#(
   parameter int SEL_W = 2,
   parameter int PSC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             cfg_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic [PSC_W-1:0] psc_wdata,
   output src_sel_e         sel_q,
   output logic [PSC_W-1:0] psc_q,
   output logic             psc_clear
);

   if (SEL_W != 2) begin : g_bad_sel_w
      $error("capsel_cfg: SEL_W must be 2");
   end
   if (PSC_W != 2) begin : g_bad_psc_w
      $error("capsel_cfg: PSC_W must be 2");
   end

   logic sel_take;

   assign sel_take  = cfg_wr && !chan_en;
   assign psc_clear = cfg_wr && (psc_wdata != psc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SRC_NONE;
         psc_q <= '0;
      end else begin
         if (sel_take) sel_q <= src_sel_e'(sel_wdata);
         if (cfg_wr)   psc_q <= psc_wdata;
      end
   end

   AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |=> $stable(sel_q)); // R6

   AST_PSC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (psc_q == $past(psc_wdata))); // R6

endmodule

// File: rtl/capsel_edge.sv
module capsel_edge #(
   parameter int NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] lvl,
   output logic [NUM-1:0] rise
);

   if (NUM < 1) begin : g_bad_num
      $error("capsel_edge: NUM must be at least 1");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_src
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end
      assign rise[i] = lvl[i] && !prev_q;

      AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> !rise[i]); // R10
   end

endmodule

// File: rtl/capsel_prescaler.sv
module capsel_prescaler
   import capsel_pkg::*;
#(
   parameter int PSC_W = 2,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clear,
   input  logic [PSC_W-1:0] psc_code,
   input  logic             edge_in,
   output logic             pulse_q
);

   localparam int MIN_CNT_W = $clog2(MAX_RATIO);

   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt_w
      $error("capsel_prescaler: CNT_W too small for the largest ratio");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;
   logic             wrap;

   assign last_val = CNT_W'(psc_ratio(psc_code) - 1);
   assign wrap     = edge_in && (cnt_q >= last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (!en || clear) begin
            cnt_q <= '0;
         end else if (wrap) begin
            cnt_q   <= '0;
            pulse_q <= 1'b1;
         end else if (edge_in) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clear)) |-> (int'(cnt_q) < psc_ratio(psc_code))); // R7

   AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0)); // R8

   AST_CLEAR_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0) && !pulse_q); // R9

endmodule

// File: rtl/capsel_front.sv
module capsel_front
   import capsel_pkg::*;
#(
   parameter int SEL_W = 2,
   parameter int PSC_W = 2,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tin1,
   input  logic             tin2,
   input  logic             trig_in,
   input  logic             chan_en,
   input  logic             cfg_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic [PSC_W-1:0] psc_wdata,
   output logic             cap_pulse
);

   src_sel_e         sel_q;
   logic [PSC_W-1:0] psc_q;
   logic             psc_clear;
   logic [N_SRC-1:0] src_lvl;
   logic [N_SRC-1:0] src_rise;
   logic             sel_edge;

   capsel_cfg #(.SEL_W(SEL_W), .PSC_W(PSC_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_en   (chan_en),
      .cfg_wr    (cfg_wr),
      .sel_wdata (sel_wdata),
      .psc_wdata (psc_wdata),
      .sel_q     (sel_q),
      .psc_q     (psc_q),
      .psc_clear (psc_clear)
   );

   // Index order follows the select code minus one.
   assign src_lvl = {trig_in, tin1, tin2};

   capsel_edge #(.NUM(N_SRC)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (src_lvl),
      .rise  (src_rise)
   );

   always_comb begin
      if (sel_q == SRC_NONE) sel_edge = 1'b0;
      else                   sel_edge = src_rise[src_index(sel_q)];
   end

   capsel_prescaler #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chan_en),
      .clear    (psc_clear),
      .psc_code (psc_q),
      .edge_in  (sel_edge),
      .pulse_q  (cap_pulse)
   );

   AST_OUTPUT_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == SRC_NONE) |=> !cap_pulse); // R2

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !cap_pulse); // R11

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> !cap_pulse); // R10

   AST_PULSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |-> $past(sel_edge)); // R10

endmodule

// File: tb/capsel_front_test.sv
module capsel_front_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tin1 = 1'b0, tin2 = 1'b0, trig_in = 1'b0;
   logic       chan_en = 1'b0, cfg_wr = 1'b0;
   logic [1:0] sel_wdata = 2'b00, psc_wdata = 2'b00;
   logic       cap_pulse;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference state
   int  m_sel = 0, m_psc = 0, m_cnt = 0;
   bit  m_prev[3];
   bit  exp_pulse = 0;

   always #10 clk = ~clk;

   capsel_front uut (
      .clk(clk), .rst_n(rst_n), .tin1(tin1), .tin2(tin2), .trig_in(trig_in),
      .chan_en(chan_en), .cfg_wr(cfg_wr), .sel_wdata(sel_wdata),
      .psc_wdata(psc_wdata), .cap_pulse(cap_pulse)
   );

   function automatic int ratio_of(int code);
      int r[4] = '{1, 2, 4, 6};
      return r[code];
   endfunction

   always @(posedge clk) begin
      bit lv[3];
      bit edg;
      bit nxt;
      lv[0] = tin2; lv[1] = tin1; lv[2] = trig_in;
      if (!rst_n) begin
         m_sel = 0; m_psc = 0; m_cnt = 0;
         for (int i = 0; i < 3; i++) m_prev[i] = 0;
         exp_pulse = 0;
      end else begin
         edg = (m_sel != 0) && lv[m_sel-1] && !m_prev[m_sel-1];
         nxt = 0;
         if (!chan_en || (cfg_wr && int'(psc_wdata) != m_psc)) m_cnt = 0;
         else if (edg) begin
            m_cnt++;
            if (m_cnt == ratio_of(m_psc)) begin m_cnt = 0; nxt = 1; end
         end
         for (int i = 0; i < 3; i++) m_prev[i] = lv[i];
         if (cfg_wr) begin
            m_psc = int'(psc_wdata);
            if (!chan_en) m_sel = int'(sel_wdata);
         end
         exp_pulse = nxt;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (cap_pulse !== exp_pulse) begin
            errors++;
            $display("FAIL %s: cap_pulse=%0b expected=%0b at %0t", cur_req, cap_pulse, exp_pulse, $time);
         end
         if (cap_pulse === 1'b1) pulses++;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] s, logic [1:0] p);
      sel_wdata = s; psc_wdata = p; cfg_wr = 1'b1;
      cyc(1);
      cfg_wr = 1'b0;
   endtask

   // which: 0 tin2, 1 tin1, 2 trig_in
   task automatic edges(int which, int n);
      for (int k = 0; k < n; k++) begin
         case (which)
            0: tin2 = 1'b1;
            1: tin1 = 1'b1;
            default: trig_in = 1'b1;
         endcase
         cyc(2);
         case (which)
            0: tin2 = 1'b0;
            1: tin1 = 1'b0;
            default: trig_in = 1'b0;
         endcase
         cyc(2);
      end
   endtask

   task automatic expect_pulses(string req, int exp);
      checks++;
      if (pulses != exp) begin
         errors++;
         $display("FAIL %s: pulse count=%0d expected=%0d", req, pulses, exp);
      end
      pulses = 0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      cyc(3);
      checks++;
      if (cap_pulse !== 1'b0) begin
         errors++;
         $display("FAIL R1: cap_pulse=%0b expected=0 in reset", cap_pulse);
      end
      rst_n = 1'b1;
      cyc(2);
      pulses = 0;

      // R2: default select 00 is output mode
      cur_req = "R2";
      chan_en = 1'b1;
      edges(0, 3); edges(1, 3); edges(2, 3);
      expect_pulses("R2", 0);

      // R4: select 10 -> tin1
      cur_req = "R4";
      chan_en = 1'b0; wr(2'b10, 2'b00); chan_en = 1'b1;
      edges(1, 4); expect_pulses("R4", 4);
      edges(0, 3); edges(2, 3); expect_pulses("R4", 0);

      // R3: select 01 -> tin2
      cur_req = "R3";
      chan_en = 1'b0; wr(2'b01, 2'b00); chan_en = 1'b1;
      edges(0, 4); expect_pulses("R3", 4);
      edges(1, 3); edges(2, 3); expect_pulses("R3", 0);

      // R5: select 11 -> trig_in
      cur_req = "R5";
      chan_en = 1'b0; wr(2'b11, 2'b00); chan_en = 1'b1;
      edges(2, 3); expect_pulses("R5", 3);
      edges(0, 3); edges(1, 3); expect_pulses("R5", 0);

      // R6: select write ignored while enabled, prescaler taken
      cur_req = "R6";
      wr(2'b10, 2'b01);
      edges(1, 4); expect_pulses("R6", 0);
      edges(2, 4); expect_pulses("R6", 2);

      // R7: ratios 2, 4, 6, first capture on k-th edge
      cur_req = "R7";
      chan_en = 1'b0; wr(2'b10, 2'b01); chan_en = 1'b1;
      edges(1, 1); expect_pulses("R7", 0);
      edges(1, 1); expect_pulses("R7", 1);
      edges(1, 3); expect_pulses("R7", 1);
      chan_en = 1'b0; wr(2'b10, 2'b10); chan_en = 1'b1;
      edges(1, 3); expect_pulses("R7", 0);
      edges(1, 5); expect_pulses("R7", 2);
      chan_en = 1'b0; wr(2'b10, 2'b11); chan_en = 1'b1;
      edges(1, 5); expect_pulses("R7", 0);
      edges(1, 1); expect_pulses("R7", 1);
      edges(1, 7); expect_pulses("R7", 1);

      // R8: disable clears the count
      cur_req = "R8";
      chan_en = 1'b0; cyc(1); chan_en = 1'b1;
      edges(1, 4);
      chan_en = 1'b0; cyc(1); chan_en = 1'b1;
      edges(1, 5); expect_pulses("R8", 0);
      edges(1, 1); expect_pulses("R8", 1);

      // R9: same-code write keeps count, changed code clears it
      cur_req = "R9";
      wr(2'b10, 2'b10);
      edges(1, 3);
      wr(2'b10, 2'b10);
      edges(1, 1); expect_pulses("R9", 1);
      edges(1, 3);
      wr(2'b10, 2'b01);
      edges(1, 1); expect_pulses("R9", 0);
      edges(1, 1); expect_pulses("R9", 1);
      // edge in the same cycle as a code change is dropped
      wr(2'b10, 2'b00);
      tin1 = 1'b1; psc_wdata = 2'b01; cfg_wr = 1'b1; cyc(1);
      cfg_wr = 1'b0; cyc(1); tin1 = 1'b0; cyc(2);
      expect_pulses("R9", 0);
      edges(1, 2); expect_pulses("R9", 1);

      // R10: level held high and falling edges give no extra pulse
      cur_req = "R10";
      wr(2'b10, 2'b00);
      tin1 = 1'b1; cyc(10); expect_pulses("R10", 1);
      tin1 = 1'b0; cyc(10); expect_pulses("R10", 0);

      // R11: disabled channel is silent
      cur_req = "R11";
      chan_en = 1'b0;
      edges(1, 4); edges(0, 2); edges(2, 2); expect_pulses("R11", 0);
      chan_en = 1'b1;
      edges(1, 2); expect_pulses("R11", 2);

      cyc(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule